// File: doc/BRIEF.md
# Serial Timekeeping Register Slave

This block is the device end of a three-wire serial clock chip. A host raises chip enable, clocks in a command byte and then moves one or more data bytes. The command selects read or write, a register address, and single-register or burst mode. The block holds seven packed-BCD calendar registers and one control register. Bit 7 of the control register is a write-protect flag.

The serial pins are sampled by a fast system clock through synchronizers, so the serial clock must be much slower than the system clock. A one-cycle tick input advances the time once per second. Reads return a snapshot that is taken when the command byte completes.

Top module: `serial_rtc_slave`

## Requirements
- R1: After reset the registers are: seconds 0x00, minutes 0x00, hours 0x00, date 0x01, month 0x01, weekday 0x01, year 0x00, control 0x80. sdo_oe_o is low.
- R2: A command byte is accepted only when all of these hold:
  - bit 7 is 1;
  - bits 6:1 hold an address of 0 to 7, or 0x1F;
  - bit 0 is 1 for a read and 0 for a write.
  
  Any other command byte makes the rest of the transaction have no effect.
- R3: Bits travel least significant first. Write data is sampled on rising serial-clock edges. A complete data byte of a single write is stored unchanged in the addressed register.
- R4: After a read command, sdo_oe_o is high while chip enable stays high. One data bit is driven per falling edge, least significant first. The first bit appears on the falling edge that follows the command's eighth rising edge. sdo_o changes on no other edge.
- R5: Address 0x1F (write command 0xBE, read command 0xBF) moves all eight registers in address order 0 to 7. The addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year, 7 control.
- R6: While control bit 7 is 1, writes to registers 0 to 6 are ignored. Writes to the control register are always accepted.
- R7: Control bits 6:0 always read as zero, whatever value is written.
- R8: If chip enable goes low mid-transaction, the transaction is aborted. The bit counter resets, a partial byte is never stored, and sdo_oe_o goes low.
- R9: Each tick_i pulse adds one to the BCD seconds. Seconds roll from 0x59 to 0x00 and carry into minutes, which likewise carry into hours. Hours roll from 0x23 to 0x00.
- R10: A tick that arrives during a read's data phase does not change the bytes returned by that read.
- R11: A command addressing 0x08 to 0x1E leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Active-high serial chip enable |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from host |
| tick_i | input | 1 | One-cycle pulse per second |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Read data output enable |

## Verification
Some rules are checked by assertions on every cycle:
- protected calendar registers stay stable;
- the control register's low bits stay zero;
- a low chip enable holds the shift state in idle with the output disabled;
- sdo moves only on a falling serial edge;
- the seconds roll over from 59.

Other behaviour only the bench scenarios can show:
- command decoding and the rejection of bad command bytes;
- burst ordering;
- that a write to the control register still lifts protection;
- that aborted partial bytes are discarded;
- that a tick landing in mid-read leaves the snapshot untouched.

// File: rtl/serial_rtc_slave.sv
module serial_rtc_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int BURST_ADDR  = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic tick_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);
  localparam int SL   = SYNC_STAGES - 1;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_DONE} phase_t;

  logic [SYNC_STAGES-1:0] ce_sy, sclk_sy, sdi_sy;
  logic       sclk_d;
  logic       ce_s, sclk_s, sdi_s, rise, fall;
  phase_t     phase;
  logic [2:0] bitcnt, rbit;
  logic [6:0] shreg;
  logic [7:0] byte_in;
  logic [IW-1:0] idx;
  logic       burst, rd_on, sdo_r;
  logic [7:0] regs [NREG];
  logic [7:0] snap [NREG];
  logic       byte_done, cmd_ok, wr_now;
  logic [5:0] cmd_addr;
  logic [8*(NREG-1)-1:0] tvec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_sy <= '0; sclk_sy <= '0; sdi_sy <= '0; sclk_d <= 1'b0;
    end else begin
      ce_sy   <= {ce_sy[SL-1:0], ce_i};
      sclk_sy <= {sclk_sy[SL-1:0], sclk_i};
      sdi_sy  <= {sdi_sy[SL-1:0], sdi_i};
      sclk_d  <= sclk_sy[SL];
    end

  assign ce_s   = ce_sy[SL];
  assign sclk_s = sclk_sy[SL];
  assign sdi_s  = sdi_sy[SL];
  assign rise   = ce_s & sclk_s & ~sclk_d;
  assign fall   = ce_s & ~sclk_s & sclk_d;

  assign byte_in   = {sdi_s, shreg};
  assign byte_done = rise && (bitcnt == 3'd7) && (phase == PH_CMD || phase == PH_WR);
  assign cmd_addr  = byte_in[6:1];
  assign cmd_ok    = byte_in[7] && (cmd_addr < 6'(NREG) || cmd_addr == 6'(BURST_ADDR));
  assign wr_now    = byte_done && phase == PH_WR && (idx == IW'(NREG-1) || !regs[NREG-1][7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_CMD; bitcnt <= '0; rbit <= '0; shreg <= '0;
      idx <= '0; burst <= 1'b0; rd_on <= 1'b0; sdo_r <= 1'b0;
      for (int k = 0; k < NREG; k++) snap[k] <= '0;
    end else if (!ce_s) begin
      phase <= PH_CMD; bitcnt <= '0; rbit <= '0; rd_on <= 1'b0;
    end else begin
      if (rise && (phase == PH_CMD || phase == PH_WR)) begin
        shreg  <= byte_in[7:1];
        bitcnt <= bitcnt + 3'd1;
      end
      if (byte_done) begin
        if (phase == PH_CMD) begin
          if (cmd_ok) begin
            burst <= (cmd_addr == 6'(BURST_ADDR));
            idx   <= (cmd_addr == 6'(BURST_ADDR)) ? '0 : cmd_addr[IW-1:0];
            if (byte_in[0]) begin
              phase <= PH_RD;
              rd_on <= 1'b1;
              rbit  <= '0;
              for (int k = 0; k < NREG; k++) snap[k] <= regs[k];
            end else begin
              phase <= PH_WR;
            end
          end else begin
            phase <= PH_DONE;
          end
        end else begin
          if (burst && idx != IW'(NREG-1)) idx <= idx + IW'(1);
          else phase <= PH_DONE;
        end
      end
      if (fall && phase == PH_RD) begin
        sdo_r <= snap[idx][rbit];
        rbit  <= rbit + 3'd1;
        if (rbit == 3'd7) begin
          if (burst && idx != IW'(NREG-1)) idx <= idx + IW'(1);
          else phase <= PH_DONE;
        end
      end
    end

  function automatic logic [7:0] bcd_inc(input logic [7:0] v, input logic [7:0] top);
    if (v == top)           return 8'h00;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return v + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      regs[0] <= 8'h00; regs[1] <= 8'h00; regs[2] <= 8'h00; regs[3] <= 8'h01;
      regs[4] <= 8'h01; regs[5] <= 8'h01; regs[6] <= 8'h00; regs[7] <= 8'h80;
    end else if (wr_now) begin
      regs[idx] <= (idx == IW'(NREG-1)) ? (byte_in & 8'h80) : byte_in;
    end else if (tick_i) begin
      regs[0] <= bcd_inc(regs[0], 8'h59);
      if (regs[0] == 8'h59) begin
        regs[1] <= bcd_inc(regs[1], 8'h59);
        if (regs[1] == 8'h59) regs[2] <= bcd_inc(regs[2], 8'h23);
      end
    end

  assign sdo_o    = sdo_r;
  assign sdo_oe_o = rd_on & ce_s;

  genvar g;
  generate
    for (g = 0; g < NREG - 1; g++) begin : g_tv
      assign tvec[8*g +: 8] = regs[g];
    end
  endgenerate

  // R6
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[NREG-1][7] && !tick_i) |=> $stable(tvec));
  // R7
  ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[NREG-1][6:0] == 7'd0);
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (bitcnt == 3'd0 && phase == PH_CMD && !sdo_oe_o));
  // R4
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_o));
  // R9
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_now && regs[0] == 8'h59) |=> regs[0] == 8'h00);
endmodule

// File: tb/serial_rtc_slave_test.sv
module serial_rtc_slave_test;
  logic clk = 0, rst_n = 0, ce = 0, sclk = 0, sdi = 0, tick = 0;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  bit done = 0;

  serial_rtc_slave uut (.clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk),
    .sdi_i(sdi), .tick_i(tick), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = b[i]; wait_clk(8); sclk = 1; wait_clk(8); sclk = 0;
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      wait_clk(8); b[i] = sdo; sclk = 1; wait_clk(8); sclk = 0;
    end
  endtask

  task automatic start_t; ce = 1; wait_clk(8); endtask
  task automatic stop_t;  wait_clk(8); ce = 0; wait_clk(16); endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] v);
    start_t; send_bits(8'h80 | (a << 1), 8); send_bits(v, 8); stop_t;
  endtask

  task automatic rd1(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    start_t; send_bits(8'h81 | (a << 1), 8);
    exp_q.push_back(e); tag_q.push_back(tag);
    recv_byte(v); act_q.push_back(v); stop_t;
  endtask

  task automatic wr_burst(input logic [7:0] d [8]);
    start_t; send_bits(8'hBE, 8);
    for (int k = 0; k < 8; k++) send_bits(d[k], 8);
    stop_t;
  endtask

  task automatic rd_burst(input logic [7:0] e [8], input string tag);
    logic [7:0] v;
    start_t; send_bits(8'hBF, 8);
    wait_clk(4); check({tag, " R4 oe during read"}, 8'(sdo_oe), 8'd1);
    for (int k = 0; k < 8; k++) begin
      exp_q.push_back(e[k]); tag_q.push_back($sformatf("%s byte%0d", tag, k));
      recv_byte(v); act_q.push_back(v);
    end
    stop_t;
    check({tag, " R8 oe after ce low"}, 8'(sdo_oe), 8'd0);
  endtask

  task automatic pulse_tick;
    @(negedge clk) tick = 1; @(negedge clk) tick = 0; wait_clk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wait_clk(5); rst_n = 1; wait_clk(5);
    check("R1 oe after reset", 8'(sdo_oe), 8'd0);
    rd_burst('{8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00,8'h80}, "R1 R5 reset values");
    wr1(7, 8'h00);
    rd1(7, 8'h00, "R6 control write accepted");
    wr1(1, 8'h45);
    rd1(1, 8'h45, "R3 R4 single write/read");
    wr_burst('{8'h58,8'h59,8'h23,8'h31,8'h12,8'h07,8'h99,8'h00});
    rd_burst('{8'h58,8'h59,8'h23,8'h31,8'h12,8'h07,8'h99,8'h00}, "R5 burst");
    pulse_tick;
    rd1(0, 8'h59, "R9 tick increment");
    pulse_tick;
    rd_burst('{8'h00,8'h00,8'h00,8'h31,8'h12,8'h07,8'h99,8'h00}, "R9 rollover");
    wr1(7, 8'h80);
    wr1(0, 8'h33);
    rd1(0, 8'h00, "R6 protected write ignored");
    wr1(7, 8'hFF);
    rd1(7, 8'h80, "R7 control low bits");
    wr1(7, 8'h00);
    wr1(0, 8'h33);
    rd1(0, 8'h33, "R6 unprotected write");
    start_t; send_bits(8'h80, 8); send_bits(8'h11, 4); stop_t;
    rd1(0, 8'h33, "R8 partial byte dropped");
    start_t; send_bits(8'h81, 3); stop_t;
    rd1(0, 8'h33, "R8 abort in command");
    start_t; send_bits(8'h02, 8); send_bits(8'h77, 8); stop_t;
    rd1(1, 8'h00, "R2 bad command ignored");
    wr1(8, 8'h55);
    rd_burst('{8'h33,8'h00,8'h00,8'h31,8'h12,8'h07,8'h99,8'h00}, "R11 bad address");
    start_t; send_bits(8'h81, 8);
    exp_q.push_back(8'h33); tag_q.push_back("R10 snapshot");
    pulse_tick;
    recv_byte(v); act_q.push_back(v); stop_t;
    rd1(0, 8'h34, "R10 tick applied after read");
    wait_clk(20);
    if (exp_q.size() != 0) check("scoreboard drain", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule